// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two independent single-word message registers that sit beside a pair of FIFO data paths and bypass them. Mailbox 1 carries a word from port A to port B; mailbox 2 carries a word from port C to port A. Port A runs on `clk_a`. Ports B and C share `clk_b`, and that clock is unrelated to `clk_a`. A per-port select input steers each access either to the mailbox or to the FIFO path. The FIFO path is outside this block: the block only passes the FIFO strobes and data through, and captures FIFO read data into the port's output register.

Each mailbox has an active-low full flag in its writer's clock domain. A write that the writer's clock accepts drives the flag low at that edge. Further writes are then refused until the reader has consumed the word. The write event reaches the reader through a two-flop synchronised toggle, and so does the release event coming back. The flag therefore returns high a few writer-clock cycles after the reader's read. A master or partial reset of a mailbox's FIFO forces that flag high and clears that FIFO's read-side output register.

Top module: `mbx_pair`

## Requirements
- R1: A `clk_a` edge with `a_wen`=1, `a_mbsel`=1 and `mb1_full_n`=1 stores `a_wdata` in mailbox 1, and `mb1_full_n` is 0 after that edge. With `a_mbsel`=0, `fifo1_we` follows `a_wen`, `fifo1_wdata` equals `a_wdata`, and neither mailbox 1 nor its flag changes.
- R2: A `clk_b` edge with `c_wen`=1, `c_mbsel`=1 and `mb2_full_n`=1 stores `c_wdata` in mailbox 2, and `mb2_full_n` is 0 after that edge. With `c_mbsel`=0, `fifo2_we` follows `c_wen`, `fifo2_wdata` equals `c_wdata`, and mailbox 2 is untouched.
- R3: While a mailbox flag is 0, a mailbox write to it is refused: the stored word and the flag do not change.
- R4: A `clk_b` edge with `b_ren`=1 and `b_mbsel`=1 loads mailbox 1's word into `b_rdata`. If that word had been delivered, `mb1_full_n` returns to 1 within five `clk_a` cycles.
- R5: A `clk_a` edge with `a_ren`=1 and `a_mbsel`=1 loads mailbox 2's word into `a_rdata`. If that word had been delivered, `mb2_full_n` returns to 1 within five `clk_b` cycles.
- R6: A read with the select at 0 captures the FIFO read data into the port's output register (`fifo1_rdata` into `b_rdata`, `fifo2_rdata` into `a_rdata`). The matching FIFO read strobe follows the read enable, and neither flag changes.
- R7: A mailbox read made when no undelivered word is waiting returns the word last stored and leaves the flag at 1.
- R8: A low level on `fifo1_mrst_n` or `fifo1_prst_n` forces `mb1_full_n` to 1 and clears `b_rdata` and mailbox 1 to zero. `fifo2_mrst_n` and `fifo2_prst_n` do the same for `mb2_full_n`, `a_rdata` and mailbox 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B and port C clock |
| fifo1_mrst_n | input | 1 | FIFO1 master reset, active low |
| fifo1_prst_n | input | 1 | FIFO1 partial reset, active low |
| fifo2_mrst_n | input | 1 | FIFO2 master reset, active low |
| fifo2_prst_n | input | 1 | FIFO2 partial reset, active low |
| a_wen | input | 1 | Port A write enable |
| a_ren | input | 1 | Port A read enable |
| a_mbsel | input | 1 | Port A select: 1 mailbox, 0 FIFO |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A output register |
| b_ren | input | 1 | Port B read enable |
| b_mbsel | input | 1 | Port B select: 1 mailbox 1, 0 FIFO1 |
| b_rdata | output | DW | Port B output register |
| c_wen | input | 1 | Port C write enable |
| c_mbsel | input | 1 | Port C select: 1 mailbox 2, 0 FIFO2 |
| c_wdata | input | DW | Port C write data |
| mb1_full_n | output | 1 | Mailbox 1 full flag, active low, `clk_a` domain |
| mb2_full_n | output | 1 | Mailbox 2 full flag, active low, `clk_b` domain |
| fifo1_we | output | 1 | FIFO1 write strobe |
| fifo1_wdata | output | DW | FIFO1 write data |
| fifo1_re | output | 1 | FIFO1 read strobe |
| fifo1_rdata | input | DW | FIFO1 output register data |
| fifo2_we | output | 1 | FIFO2 write strobe |
| fifo2_wdata | output | DW | FIFO2 write data |
| fifo2_re | output | 1 | FIFO2 read strobe |
| fifo2_rdata | input | DW | FIFO2 output register data |

## Verification
Each mailbox is taken through a full round trip: a write, a blocked second write with different data, a delayed read on the far clock, and then the flag's return. The far read must show the first word, which separates a working write block from a last-write-wins register. A repeated read after the release must return the same word with the flag left high, which separates a stale read from a false second release. FIFO-selected writes and reads are mixed in to show that the select steers strobes and read data without touching either mailbox. Partial and master resets are applied while a flag is low, to show that the flag, the mailbox word and the output register clear, and that a later stale read returns zero.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // Default depth of each clock-crossing synchroniser.
    localparam int unsigned SYNC_DEPTH = 2;

    // Source of a port's output register on a read.
    typedef enum logic {
        SRC_FIFO = 1'b0,
        SRC_MAIL = 1'b1
    } rd_src_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int unsigned DW     = 36,
    parameter int unsigned STAGES = mbx_pkg::SYNC_DEPTH
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          full_n,
    output logic [DW-1:0] mail_q,
    input  logic          rd_req
);
    typedef struct packed {
        logic          tog;
        logic [DW-1:0] word;
    } wside_t;

    typedef struct packed {
        logic tog;
    } rside_t;

    wside_t w_d, w_q;
    rside_t r_d, r_q;

    logic rtog_in_w;   // reader toggle seen in writer domain
    logic wtog_in_r;   // writer toggle seen in reader domain
    logic occupied;
    logic waiting;

    mbx_sync #(.STAGES(STAGES)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (r_q.tog),
        .q     (rtog_in_w)
    );

    mbx_sync #(.STAGES(STAGES)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (w_q.tog),
        .q     (wtog_in_r)
    );

    // Writer side: a write is accepted only while the mailbox is empty.
    always_comb begin
        occupied = w_q.tog ^ rtog_in_w;
        w_d      = w_q;
        if (wr_req && !occupied) begin
            w_d.tog  = ~w_q.tog;
            w_d.word = wr_data;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    // Reader side: only a read of a delivered word sends the release.
    always_comb begin
        waiting = wtog_in_r ^ r_q.tog;
        r_d     = r_q;
        if (rd_req && waiting) r_d.tog = ~r_q.tog;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign full_n = ~occupied;
    assign mail_q = w_q.word;
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair #(
    parameter int unsigned DW     = 36,
    parameter int unsigned STAGES = mbx_pkg::SYNC_DEPTH
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          fifo1_mrst_n,
    input  logic          fifo1_prst_n,
    input  logic          fifo2_mrst_n,
    input  logic          fifo2_prst_n,
    input  logic          a_wen,
    input  logic          a_ren,
    input  logic          a_mbsel,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_ren,
    input  logic          b_mbsel,
    output logic [DW-1:0] b_rdata,
    input  logic          c_wen,
    input  logic          c_mbsel,
    input  logic [DW-1:0] c_wdata,
    output logic          mb1_full_n,
    output logic          mb2_full_n,
    output logic          fifo1_we,
    output logic [DW-1:0] fifo1_wdata,
    output logic          fifo1_re,
    input  logic [DW-1:0] fifo1_rdata,
    output logic          fifo2_we,
    output logic [DW-1:0] fifo2_wdata,
    output logic          fifo2_re,
    input  logic [DW-1:0] fifo2_rdata
);
    import mbx_pkg::*;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } oreg_t;

    logic          rst1_n, rst2_n;
    logic [DW-1:0] mail1_q, mail2_q;
    rd_src_e       a_src, b_src;
    oreg_t         a_d, a_q, b_d, b_q;

    // Either reset of a FIFO clears that FIFO's mailbox.
    assign rst1_n = fifo1_mrst_n & fifo1_prst_n;
    assign rst2_n = fifo2_mrst_n & fifo2_prst_n;

    mbx_channel #(.DW(DW), .STAGES(STAGES)) u_mail1 (
        .wclk    (clk_a),
        .rclk    (clk_b),
        .rst_n   (rst1_n),
        .wr_req  (a_wen & a_mbsel),
        .wr_data (a_wdata),
        .full_n  (mb1_full_n),
        .mail_q  (mail1_q),
        .rd_req  (b_ren & b_mbsel)
    );

    mbx_channel #(.DW(DW), .STAGES(STAGES)) u_mail2 (
        .wclk    (clk_b),
        .rclk    (clk_a),
        .rst_n   (rst2_n),
        .wr_req  (c_wen & c_mbsel),
        .wr_data (c_wdata),
        .full_n  (mb2_full_n),
        .mail_q  (mail2_q),
        .rd_req  (a_ren & a_mbsel)
    );

    // FIFO-side strobes pass straight through when the select is low.
    assign fifo1_we    = a_wen & ~a_mbsel;
    assign fifo1_wdata = a_wdata;
    assign fifo2_we    = c_wen & ~c_mbsel;
    assign fifo2_wdata = c_wdata;
    assign fifo1_re    = b_ren & ~b_mbsel;
    assign fifo2_re    = a_ren & ~a_mbsel;

    assign a_src = rd_src_e'(a_mbsel);
    assign b_src = rd_src_e'(b_mbsel);

    // Port A output register (cleared with FIFO2).
    always_comb begin
        a_d = a_q;
        if (a_ren) a_d.rdata = (a_src == SRC_MAIL) ? mail2_q : fifo2_rdata;
    end

    always_ff @(posedge clk_a or negedge rst2_n) begin
        if (!rst2_n) a_q <= '0;
        else         a_q <= a_d;
    end

    // Port B output register (cleared with FIFO1).
    always_comb begin
        b_d = b_q;
        if (b_ren) b_d.rdata = (b_src == SRC_MAIL) ? mail1_q : fifo1_rdata;
    end

    always_ff @(posedge clk_b or negedge rst1_n) begin
        if (!rst1_n) b_q <= '0;
        else         b_q <= b_d;
    end

    assign a_rdata = a_q.rdata;
    assign b_rdata = b_q.rdata;
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
    parameter int unsigned DW = 36
) (
    input logic          clk_a,
    input logic          clk_b,
    input logic          rst1_n,
    input logic          rst2_n,
    input logic          a_wen,
    input logic          a_ren,
    input logic          a_mbsel,
    input logic [DW-1:0] a_wdata,
    input logic [DW-1:0] a_rdata,
    input logic          b_ren,
    input logic          b_mbsel,
    input logic [DW-1:0] b_rdata,
    input logic          c_wen,
    input logic          c_mbsel,
    input logic [DW-1:0] c_wdata,
    input logic          mb1_full_n,
    input logic          mb2_full_n,
    input logic [DW-1:0] mail1_q,
    input logic [DW-1:0] mail2_q,
    input logic [DW-1:0] fifo1_rdata,
    input logic [DW-1:0] fifo2_rdata
);
    // R1
    mb1_take_chk: assert property (@(posedge clk_a) disable iff (!rst1_n)
        (mb1_full_n && a_wen && a_mbsel) |=> (!mb1_full_n && mail1_q == $past(a_wdata)));
    // R1
    mb1_steer_chk: assert property (@(posedge clk_a) disable iff (!rst1_n)
        (a_wen && !a_mbsel) |=> $stable(mail1_q));
    // R1
    mb1_fall_chk: assert property (@(posedge clk_a) disable iff (!rst1_n)
        $fell(mb1_full_n) |-> $past(a_wen && a_mbsel));
    // R3
    mb1_block_chk: assert property (@(posedge clk_a) disable iff (!rst1_n)
        (!mb1_full_n && a_wen && a_mbsel) |=> $stable(mail1_q));
    // R2
    mb2_take_chk: assert property (@(posedge clk_b) disable iff (!rst2_n)
        (mb2_full_n && c_wen && c_mbsel) |=> (!mb2_full_n && mail2_q == $past(c_wdata)));
    // R2
    mb2_steer_chk: assert property (@(posedge clk_b) disable iff (!rst2_n)
        (c_wen && !c_mbsel) |=> $stable(mail2_q));
    // R3
    mb2_block_chk: assert property (@(posedge clk_b) disable iff (!rst2_n)
        (!mb2_full_n && c_wen && c_mbsel) |=> $stable(mail2_q));
    // R4
    b_mail_rd_chk: assert property (@(posedge clk_b) disable iff (!rst1_n)
        (b_ren && b_mbsel) |=> (b_rdata == $past(mail1_q)));
    // R5
    a_mail_rd_chk: assert property (@(posedge clk_a) disable iff (!rst2_n)
        (a_ren && a_mbsel) |=> (a_rdata == $past(mail2_q)));
    // R6
    b_fifo_rd_chk: assert property (@(posedge clk_b) disable iff (!rst1_n)
        (b_ren && !b_mbsel) |=> (b_rdata == $past(fifo1_rdata)));
    // R6
    a_fifo_rd_chk: assert property (@(posedge clk_a) disable iff (!rst2_n)
        (a_ren && !a_mbsel) |=> (a_rdata == $past(fifo2_rdata)));
    // R8
    rst1_clear_chk: assert property (@(posedge clk_a)
        !rst1_n |-> (mb1_full_n && b_rdata == '0 && mail1_q == '0));
    // R8
    rst2_clear_chk: assert property (@(posedge clk_b)
        !rst2_n |-> (mb2_full_n && a_rdata == '0 && mail2_q == '0));
endmodule

bind mbx_pair mbx_pair_chk #(.DW(DW)) u_chk (
    .clk_a       (clk_a),
    .clk_b       (clk_b),
    .rst1_n      (rst1_n),
    .rst2_n      (rst2_n),
    .a_wen       (a_wen),
    .a_ren       (a_ren),
    .a_mbsel     (a_mbsel),
    .a_wdata     (a_wdata),
    .a_rdata     (a_rdata),
    .b_ren       (b_ren),
    .b_mbsel     (b_mbsel),
    .b_rdata     (b_rdata),
    .c_wen       (c_wen),
    .c_mbsel     (c_mbsel),
    .c_wdata     (c_wdata),
    .mb1_full_n  (mb1_full_n),
    .mb2_full_n  (mb2_full_n),
    .mail1_q     (mail1_q),
    .mail2_q     (mail2_q),
    .fifo1_rdata (fifo1_rdata),
    .fifo2_rdata (fifo2_rdata)
);

// File: tb/mbx_pair_tb_top.sv
`timescale 1ns/1ps
module mbx_pair_tb_top;
    localparam int DW = 36;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic fifo1_mrst_n = 1'b0, fifo1_prst_n = 1'b1;
    logic fifo2_mrst_n = 1'b0, fifo2_prst_n = 1'b1;
    logic a_wen = 0, a_ren = 0, a_mbsel = 0;
    logic b_ren = 0, b_mbsel = 0;
    logic c_wen = 0, c_mbsel = 0;
    logic [DW-1:0] a_wdata = '0, c_wdata = '0, fifo1_rdata = '0, fifo2_rdata = '0;
    logic [DW-1:0] a_rdata, b_rdata, fifo1_wdata, fifo2_wdata;
    logic mb1_full_n, mb2_full_n, fifo1_we, fifo1_re, fifo2_we, fifo2_re;

    int n_chk = 0, n_bad = 0;

    // Behavioural reference: occupancy and stored words per mailbox.
    bit m1_full = 0, m2_full = 0;
    bit m1_known = 0, m2_known = 0;
    logic [DW-1:0] m1_word = '0, m2_word = '0;

    always #10 clk_a = ~clk_a;   // 50 MHz
    always #13 clk_b = ~clk_b;

    mbx_pair #(.DW(DW)) dut_i (.*);

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the flags against the reference model.
    always @(negedge clk_a) if (m1_known) check("R1/R3/R4 flag1", DW'(mb1_full_n), DW'(!m1_full));
    always @(negedge clk_b) if (m2_known) check("R2/R3/R5 flag2", DW'(mb2_full_n), DW'(!m2_full));

    task automatic a_write(bit sel, logic [DW-1:0] d);
        @(negedge clk_a);
        a_wen = 1; a_mbsel = sel; a_wdata = d;
        #1 check("R1 fifo1_we", DW'(fifo1_we), DW'(!sel));
        if (!sel) check("R1 fifo1_wdata", fifo1_wdata, d);
        @(posedge clk_a);
        if (sel && !m1_full) begin m1_full = 1; m1_word = d; end
        @(negedge clk_a);
        a_wen = 0; a_mbsel = 0;
    endtask

    task automatic c_write(bit sel, logic [DW-1:0] d);
        @(negedge clk_b);
        c_wen = 1; c_mbsel = sel; c_wdata = d;
        #1 check("R2 fifo2_we", DW'(fifo2_we), DW'(!sel));
        if (!sel) check("R2 fifo2_wdata", fifo2_wdata, d);
        @(posedge clk_b);
        if (sel && !m2_full) begin m2_full = 1; m2_word = d; end
        @(negedge clk_b);
        c_wen = 0; c_mbsel = 0;
    endtask

    // Port B read; mailbox reads release a delivered word.
    task automatic b_read(bit sel, logic [DW-1:0] fd, string req);
        bit rel;
        @(negedge clk_b);
        b_ren = 1; b_mbsel = sel; fifo1_rdata = fd;
        #1 check("R6 fifo1_re", DW'(fifo1_re), DW'(!sel));
        @(posedge clk_b);
        rel = sel && m1_full;
        if (rel) m1_known = 0;
        @(negedge clk_b);
        b_ren = 0; b_mbsel = 0;
        check(req, b_rdata, sel ? m1_word : fd);
        if (rel) begin
            repeat (5) @(negedge clk_a);
            m1_full = 0; m1_known = 1;
            #1 check("R4 flag1 released", DW'(mb1_full_n), DW'(1));
        end
    endtask

    task automatic a_read(bit sel, logic [DW-1:0] fd, string req);
        bit rel;
        @(negedge clk_a);
        a_ren = 1; a_mbsel = sel; fifo2_rdata = fd;
        #1 check("R6 fifo2_re", DW'(fifo2_re), DW'(!sel));
        @(posedge clk_a);
        rel = sel && m2_full;
        if (rel) m2_known = 0;
        @(negedge clk_a);
        a_ren = 0; a_mbsel = 0;
        check(req, a_rdata, sel ? m2_word : fd);
        if (rel) begin
            repeat (5) @(negedge clk_b);
            m2_full = 0; m2_known = 1;
            #1 check("R5 flag2 released", DW'(mb2_full_n), DW'(1));
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk_b);
        // R8 reset state
        check("R8 reset flag1", DW'(mb1_full_n), DW'(1));
        check("R8 reset flag2", DW'(mb2_full_n), DW'(1));
        check("R8 reset a_rdata", a_rdata, '0);
        check("R8 reset b_rdata", b_rdata, '0);
        fifo1_mrst_n = 1; fifo2_mrst_n = 1;
        m1_known = 1; m2_known = 1;
        repeat (3) @(negedge clk_a);

        // Mailbox 1 round trip with a refused second write.
        a_write(1, 36'h1_2345_6789);                         // R1
        a_write(1, 36'hA_AAAA_AAAA);                         // R3
        check("R3 flag1 held low", DW'(mb1_full_n), DW'(0));
        repeat (4) @(negedge clk_b);
        b_read(1, 36'h0, "R4 b_rdata mail1");
        b_read(1, 36'h0, "R7 stale mail1");                  // R7
        repeat (4) @(negedge clk_a);
        check("R7 flag1 stays high", DW'(mb1_full_n), DW'(1));

        // FIFO steering on ports A and B.
        a_write(0, 36'h5_0505_0505);                         // R1
        check("R1 fifo write no flag", DW'(mb1_full_n), DW'(1));
        b_read(0, 36'hF_00D0_0F00, "R6 b_rdata fifo1");

        // Mailbox 2 round trip.
        c_write(1, 36'h9_8765_4321);                         // R2
        c_write(1, 36'h3_3333_3333);                         // R3
        c_write(0, 36'h7_7777_0000);                         // R2
        repeat (4) @(negedge clk_a);
        a_read(0, 36'hC_CCCC_1111, "R6 a_rdata fifo2");
        check("R6 flag2 unchanged", DW'(mb2_full_n), DW'(0));
        a_read(1, 36'h0, "R5 a_rdata mail2");
        a_read(1, 36'h0, "R7 stale mail2");

        // Second mailbox 1 word after release.
        a_write(1, 36'h0_FEED_BEEF);                         // R1
        repeat (4) @(negedge clk_b);
        b_read(1, 36'h0, "R4 b_rdata second word");

        // Partial reset of FIFO1 while mailbox 1 is full.
        a_write(1, 36'hB_BBBB_BBBB);
        repeat (4) @(negedge clk_b);
        @(negedge clk_a);
        m1_known = 0;
        fifo1_prst_n = 0;
        #1 check("R8 prst flag1", DW'(mb1_full_n), DW'(1));
        check("R8 prst b_rdata", b_rdata, '0);
        repeat (3) @(negedge clk_a);
        fifo1_prst_n = 1;
        m1_full = 0; m1_word = '0; m1_known = 1;
        repeat (3) @(negedge clk_b);
        b_read(1, 36'h0, "R8 stale after reset");

        // Master reset of FIFO2 while mailbox 2 is full.
        c_write(1, 36'h4_4444_4444);
        a_read(0, 36'h1_0000_0001, "R6 a_rdata fifo2 again");
        @(negedge clk_b);
        m2_known = 0;
        fifo2_mrst_n = 0;
        #1 check("R8 mrst flag2", DW'(mb2_full_n), DW'(1));
        check("R8 mrst a_rdata", a_rdata, '0);
        repeat (5) @(negedge clk_b);
        fifo2_mrst_n = 1;
        m2_full = 0; m2_word = '0; m2_known = 1;
        repeat (3) @(negedge clk_a);
        a_read(1, 36'h0, "R8 stale mail2 after reset");

        repeat (3) @(negedge clk_a);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule